// File: doc/BRIEF.md
# Data I/O Channel File

This block is the 4-bit data channel unit of a small controller. Eight channel numbers are selected by an operand carried with each command. Channel 0 is an input-only channel with no storage. Channels 1 and 2 are shared input/output channels. Each has a 4-bit register that controls an open-drain pin group. Channel 3 is an output channel backed by a 4-bit register. Channels 4, 5 and 6 are pinless 4-bit registers whose contents leave the block as display-mode control words. Channel 7 is unassigned.

Writes use one transfer path for every register, whether the register has pins or not. A write updates the addressed register at the next clock edge. A read samples the addressed source at the clock edge of the command and places it on a registered read-data output. For channels 0 to 2 the source is the pin level. For channels 3 to 6 it is the register contents. The pin levels of channels 1 and 2 are the wired-AND of the external drivers and this block's pull-downs, so a channel register bit must be 1 for the external level on that pin to be read.

Top module: `dio_chanfile`

## Requirements
- R1: While reset is high at a clock edge (synchronous, active high), the registers of channels 1 to 6 load 4'hF. After that edge `out_r3` and all three mode outputs read 4'hF, both pull-low outputs read 4'h0, and `rd_data` reads 4'h0.
- R2: A command with `cmd_valid`=1, `cmd_write`=1 and `cmd_chan` equal to n (binary, 1 to 6) loads `cmd_wdata` into the register of channel n at that clock edge. No other register changes.
- R3: A write command whose `cmd_chan` is 0 or 7 changes no register. Every pin-control and mode output keeps its value.
- R4: For channels 1 and 2, bit i of the pull-low output is 1 exactly when bit i of that channel's register is 0. A 1 in the register releases the pin.
- R5: A read command (`cmd_valid`=1, `cmd_write`=0) to channel 0, 1 or 2 sets `rd_data`, one cycle later, to the pin input of that channel sampled at the command's clock edge.
- R6: A read command to channel 3, 4, 5 or 6 sets `rd_data`, one cycle later, to that register's contents at the command's clock edge.
- R7: A read command to channel 7 sets `rd_data` to 4'h0 one cycle later.
- R8: In a cycle with no read command, `rd_data` keeps its value.
- R9: `out_r3`, `mode_r4`, `mode_r5` and `mode_r6` always equal the contents of the registers of channels 3, 4, 5 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_chan | input | 3 | Channel number operand (0 to 7) |
| cmd_wdata | input | 4 | Write data |
| pin_r0 | input | 4 | Pin levels of input channel 0 |
| pin_io1 | input | 4 | Resolved pin levels of channel 1 |
| pin_io2 | input | 4 | Resolved pin levels of channel 2 |
| rd_data | output | 4 | Registered read data |
| io1_pull_low | output | 4 | Open-drain pull-down enables of channel 1 |
| io2_pull_low | output | 4 | Open-drain pull-down enables of channel 2 |
| out_r3 | output | 4 | Output pins of channel 3 |
| mode_r4 | output | 4 | Display-mode word from channel 4 |
| mode_r5 | output | 4 | Display-mode word from channel 5 |
| mode_r6 | output | 4 | Display-mode word from channel 6 |

## Verification
The bound checker watches several properties on every cycle. It checks that writes to channels 0 and 7 leave every pin-control and mode output stable. It checks that a write to a channel shows up on that channel's output or pull-low pins one cycle later, and that the pull-low enables follow the inverse of the written data. It also checks the one-cycle read latency for pin and register sources, the zero returned for channel 7, and that `rd_data` holds when there is no read. The bench models the wired-AND of external drivers and pull-downs on channels 1 and 2, so reads of those pins compare the value the register lets through, and only its scenarios show this. Only the bench's scenarios also show the reset values, and that a write to one register leaves the other five registers unchanged over long random command streams.

// File: rtl/dio_pkg.sv
package dio_pkg;

    localparam int DW       = 4;
    localparam int CW       = 3;
    localparam int NREG     = 6;
    localparam int NBIDIR   = 2;
    localparam int NMODE    = 3;
    localparam logic [DW-1:0] REG_RST = {DW{1'b1}};
    localparam logic [DW-1:0] RD_RST  = {DW{1'b0}};

    typedef enum logic [CW-1:0] {
        CH_IN0   = 3'd0,
        CH_BI1   = 3'd1,
        CH_BI2   = 3'd2,
        CH_OUT3  = 3'd3,
        CH_MODE4 = 3'd4,
        CH_MODE5 = 3'd5,
        CH_MODE6 = 3'd6,
        CH_NONE7 = 3'd7
    } chan_e;

    typedef struct packed {
        logic          valid;
        logic          write;
        chan_e         chan;
        logic [DW-1:0] data;
    } cmd_t;

    // register k of the bank belongs to channel k+1
    typedef logic [NREG-1:0][DW-1:0] regfile_t;

    function automatic logic chan_has_reg(chan_e c);
        return (c >= CH_BI1) && (c <= CH_MODE6);
    endfunction

    function automatic logic chan_reads_pin(chan_e c);
        return c <= CH_BI2;
    endfunction

    function automatic int unsigned reg_slot(chan_e c);
        return int'(c) - 1;
    endfunction

endpackage

// File: rtl/dio_reg_bank.sv
module dio_reg_bank
    import dio_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  cmd_t     cmd,
    output regfile_t regs
);

    logic wr_any;

    always_comb begin
        wr_any = cmd.valid && cmd.write && chan_has_reg(cmd.chan);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NREG; k++) begin
                regs[k] <= REG_RST;
            end
        end else if (wr_any) begin
            for (int k = 0; k < NREG; k++) begin
                if (cmd.chan == chan_e'(CW'(k + 1))) begin
                    regs[k] <= cmd.data;
                end
            end
        end
    end

endmodule

// File: rtl/dio_pin_map.sv
module dio_pin_map
    import dio_pkg::*;
(
    input  regfile_t                    regs,
    output logic [NBIDIR-1:0][DW-1:0]   pull_low,
    output logic [DW-1:0]               out_pins,
    output logic [NMODE-1:0][DW-1:0]    mode_words
);

    localparam int BIDIR_BASE = int'(CH_BI1) - 1;
    localparam int MODE_BASE  = int'(CH_MODE4) - 1;

    generate
        for (genvar b = 0; b < NBIDIR; b++) begin : g_bidir
            // open drain: a 0 in the register pulls the pin down
            assign pull_low[b] = ~regs[BIDIR_BASE + b];
        end
        for (genvar m = 0; m < NMODE; m++) begin : g_mode
            assign mode_words[m] = regs[MODE_BASE + m];
        end
    endgenerate

    assign out_pins = regs[int'(CH_OUT3) - 1];

endmodule

// File: rtl/dio_read_port.sv
module dio_read_port
    import dio_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  cmd_t          cmd,
    input  regfile_t      regs,
    input  logic [DW-1:0] pin0,
    input  logic [DW-1:0] pin1,
    input  logic [DW-1:0] pin2,
    output logic [DW-1:0] rd_q
);

    logic          rd_en;
    logic [DW-1:0] rd_sel;

    always_comb begin
        rd_en = cmd.valid && !cmd.write;
        unique case (cmd.chan)
            CH_IN0:   rd_sel = pin0;
            CH_BI1:   rd_sel = pin1;
            CH_BI2:   rd_sel = pin2;
            CH_OUT3,
            CH_MODE4,
            CH_MODE5,
            CH_MODE6: rd_sel = regs[reg_slot(cmd.chan)];
            default:  rd_sel = RD_RST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= RD_RST;
        end else if (rd_en) begin
            rd_q <= rd_sel;
        end
    end

endmodule

// File: rtl/dio_chanfile.sv
module dio_chanfile
    import dio_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic       cmd_write,
    input  logic [2:0] cmd_chan,
    input  logic [3:0] cmd_wdata,
    input  logic [3:0] pin_r0,
    input  logic [3:0] pin_io1,
    input  logic [3:0] pin_io2,
    output logic [3:0] rd_data,
    output logic [3:0] io1_pull_low,
    output logic [3:0] io2_pull_low,
    output logic [3:0] out_r3,
    output logic [3:0] mode_r4,
    output logic [3:0] mode_r5,
    output logic [3:0] mode_r6
);

    cmd_t                       cmd;
    regfile_t                   regs;
    logic [NBIDIR-1:0][DW-1:0]  pull_low;
    logic [NMODE-1:0][DW-1:0]   mode_words;

    always_comb begin
        cmd.valid = cmd_valid;
        cmd.write = cmd_write;
        cmd.chan  = chan_e'(cmd_chan);
        cmd.data  = cmd_wdata;
    end

    dio_reg_bank u_bank (
        .clk  (clk),
        .rst  (rst),
        .cmd  (cmd),
        .regs (regs)
    );

    dio_pin_map u_map (
        .regs       (regs),
        .pull_low   (pull_low),
        .out_pins   (out_r3),
        .mode_words (mode_words)
    );

    dio_read_port u_rd (
        .clk  (clk),
        .rst  (rst),
        .cmd  (cmd),
        .regs (regs),
        .pin0 (pin_r0),
        .pin1 (pin_io1),
        .pin2 (pin_io2),
        .rd_q (rd_data)
    );

    assign io1_pull_low = pull_low[0];
    assign io2_pull_low = pull_low[1];
    assign mode_r4      = mode_words[0];
    assign mode_r5      = mode_words[1];
    assign mode_r6      = mode_words[2];

endmodule

// File: rtl/dio_chanfile_chk.sv
module dio_chanfile_chk (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic       cmd_write,
    input logic [2:0] cmd_chan,
    input logic [3:0] cmd_wdata,
    input logic [3:0] pin_r0,
    input logic [3:0] pin_io1,
    input logic [3:0] rd_data,
    input logic [3:0] io1_pull_low,
    input logic [3:0] io2_pull_low,
    input logic [3:0] out_r3,
    input logic [3:0] mode_r4,
    input logic [3:0] mode_r5,
    input logic [3:0] mode_r6
);

    logic wr_cmd, rd_cmd;
    assign wr_cmd = cmd_valid && cmd_write;
    assign rd_cmd = cmd_valid && !cmd_write;

    assert_nowrite_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        wr_cmd && (cmd_chan == 3'd0 || cmd_chan == 3'd7) |=>
            $stable(io1_pull_low) && $stable(io2_pull_low) && $stable(out_r3)
            && $stable(mode_r4) && $stable(mode_r5) && $stable(mode_r6));

    assert_out3_write_R2: assert property (@(posedge clk) disable iff (rst)
        wr_cmd && cmd_chan == 3'd3 |=> out_r3 == $past(cmd_wdata));

    assert_mode5_write_R9: assert property (@(posedge clk) disable iff (rst)
        wr_cmd && cmd_chan == 3'd5 |=> mode_r5 == $past(cmd_wdata));

    assert_opendrain_io1_R4: assert property (@(posedge clk) disable iff (rst)
        wr_cmd && cmd_chan == 3'd1 |=> io1_pull_low == ~$past(cmd_wdata));

    assert_opendrain_io2_R4: assert property (@(posedge clk) disable iff (rst)
        wr_cmd && cmd_chan == 3'd2 |=> io2_pull_low == ~$past(cmd_wdata));

    assert_pin0_read_R5: assert property (@(posedge clk) disable iff (rst)
        rd_cmd && cmd_chan == 3'd0 |=> rd_data == $past(pin_r0));

    assert_pin1_read_R5: assert property (@(posedge clk) disable iff (rst)
        rd_cmd && cmd_chan == 3'd1 |=> rd_data == $past(pin_io1));

    assert_mode4_read_R6: assert property (@(posedge clk) disable iff (rst)
        rd_cmd && cmd_chan == 3'd4 |=> rd_data == $past(mode_r4));

    assert_none7_read_R7: assert property (@(posedge clk) disable iff (rst)
        rd_cmd && cmd_chan == 3'd7 |=> rd_data == 4'h0);

    assert_rd_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !rd_cmd |=> $stable(rd_data));

endmodule

bind dio_chanfile dio_chanfile_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .cmd_valid    (cmd_valid),
    .cmd_write    (cmd_write),
    .cmd_chan     (cmd_chan),
    .cmd_wdata    (cmd_wdata),
    .pin_r0       (pin_r0),
    .pin_io1      (pin_io1),
    .rd_data      (rd_data),
    .io1_pull_low (io1_pull_low),
    .io2_pull_low (io2_pull_low),
    .out_r3       (out_r3),
    .mode_r4      (mode_r4),
    .mode_r5      (mode_r5),
    .mode_r6      (mode_r6)
);

// File: tb/dio_chanfile_bench.sv
module dio_chanfile_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       cmd_valid, cmd_write;
    logic [2:0] cmd_chan;
    logic [3:0] cmd_wdata;
    logic [3:0] ext0, ext1, ext2;
    logic [3:0] pin_r0, pin_io1, pin_io2;
    logic [3:0] rd_data, io1_pull_low, io2_pull_low;
    logic [3:0] out_r3, mode_r4, mode_r5, mode_r6;

    int checks = 0;
    int errors = 0;

    logic [3:0] m_reg [1:6];
    logic [3:0] m_rd;

    always #4 clk = ~clk;

    // external drivers wired-AND with the block's pull-downs
    assign pin_r0  = ext0;
    assign pin_io1 = ext1 & ~io1_pull_low;
    assign pin_io2 = ext2 & ~io2_pull_low;

    dio_chanfile u_dio_chanfile (
        .clk          (clk),
        .rst          (rst),
        .cmd_valid    (cmd_valid),
        .cmd_write    (cmd_write),
        .cmd_chan     (cmd_chan),
        .cmd_wdata    (cmd_wdata),
        .pin_r0       (pin_r0),
        .pin_io1      (pin_io1),
        .pin_io2      (pin_io2),
        .rd_data      (rd_data),
        .io1_pull_low (io1_pull_low),
        .io2_pull_low (io2_pull_low),
        .out_r3       (out_r3),
        .mode_r4      (mode_r4),
        .mode_r5      (mode_r5),
        .mode_r6      (mode_r6)
    );

    function automatic logic [3:0] exp_read(logic [2:0] ch);
        case (ch)
            3'd0:    return ext0;
            3'd1:    return ext1 & m_reg[1];
            3'd2:    return ext2 & m_reg[2];
            3'd7:    return 4'h0;
            default: return m_reg[ch];
        endcase
    endfunction

    task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_outputs(string req);
        chk({req, " R4 io1"}, io1_pull_low, ~m_reg[1]);
        chk({req, " R4 io2"}, io2_pull_low, ~m_reg[2]);
        chk({req, " R9 out3"}, out_r3, m_reg[3]);
        chk({req, " R9 mode4"}, mode_r4, m_reg[4]);
        chk({req, " R9 mode5"}, mode_r5, m_reg[5]);
        chk({req, " R9 mode6"}, mode_r6, m_reg[6]);
    endtask

    // drive at a falling edge, check at the next falling edge
    task automatic issue(logic v, logic w, logic [2:0] ch, logic [3:0] d, string req);
        @(negedge clk);
        cmd_valid = v; cmd_write = w; cmd_chan = ch; cmd_wdata = d;
        if (v && !w) m_rd = exp_read(ch);
        if (v && w && ch >= 3'd1 && ch <= 3'd6) m_reg[ch] = d;
        @(negedge clk);
        chk({req, " rd_data"}, rd_data, m_rd);
        chk_outputs(req);
        cmd_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; cmd_valid = 1'b0; cmd_write = 1'b0;
        cmd_chan = 3'd0; cmd_wdata = 4'h0;
        ext0 = 4'h0; ext1 = 4'hF; ext2 = 4'hF;
        for (int k = 1; k <= 6; k++) m_reg[k] = 4'hF;
        m_rd = 4'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 rd_data", rd_data, 4'h0);
        chk_outputs("R1");

        // R2 writes land only in the addressed register
        issue(1, 1, 3'd3, 4'h5, "R2 w3");
        issue(1, 1, 3'd6, 4'h2, "R2 w6");
        // R3 writes to channel 0 and 7 are ignored
        issue(1, 1, 3'd0, 4'h0, "R3 w0");
        issue(1, 1, 3'd7, 4'h0, "R3 w7");
        // R4/R5 open drain: released bits let external level through
        ext1 = 4'hF;
        issue(1, 1, 3'd1, 4'hA, "R4 w1");
        issue(1, 0, 3'd1, 4'h0, "R5 r1");
        chk("R5 r1 direct", rd_data, 4'hA);
        ext0 = 4'h9;
        issue(1, 0, 3'd0, 4'h0, "R5 r0");
        // R6 register read, R7 unassigned read
        issue(1, 0, 3'd6, 4'h0, "R6 r6");
        chk("R6 r6 direct", rd_data, 4'h2);
        issue(1, 0, 3'd7, 4'h0, "R7 r7");
        chk("R7 r7 direct", rd_data, 4'h0);
        // R8 hold with idle cycle and with a write
        issue(1, 0, 3'd3, 4'h0, "R6 r3");
        issue(0, 0, 3'd3, 4'h0, "R8 idle");
        issue(1, 1, 3'd4, 4'h7, "R8 write");
        chk("R8 hold direct", rd_data, 4'h5);

        for (int i = 0; i < 600; i++) begin
            ext0 = 4'($urandom);
            ext1 = 4'($urandom);
            ext2 = 4'($urandom);
            issue($urandom_range(0, 7) != 0, 1'($urandom), 3'($urandom),
                  4'($urandom), "R2/R5/R6/R8 rand");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule